// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock period. In a single cycle it fetches a word from a local instruction store, reads two operands from a 32-entry register file, computes in an ALU, optionally touches a local data store and writes back. It runs four instruction classes: register-to-register arithmetic and logic, word load, word store and branch-if-equal. There are no jumps, exceptions or pipeline stages.

The datapath joins four simpler paths: fetch, register format, memory reference and branch. They meet at four multiplexers: write-address select, ALU-operand select, write-back select and next-PC select. A purely combinational decoder drives the seven control lines from the 6-bit opcode alone. A second small decoder turns the function field into an ALU operation. Both stores are filled through a preload port, usually while reset is held. The write-back, store and PC activity appear on output ports so that results can be observed.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0. This takes effect without waiting for a clock edge. Reset clears the registers but leaves both memories unchanged.
- R2: Every instruction except a taken branch sets the next PC to PC + 4. This sum comes from an adder separate from the ALU.
- R3: Opcode 6'b000000 is register format. It writes `rd` (bits 15:11) with rs OP rt, where `rs` is bits 25:21 and `rt` is bits 20:16. The function field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than (result 1 or 0).
- R4: Opcode 6'b100011 loads a word. The byte address is rs + sign-extended bits 15:0. The word read there is written into `rt`.
- R5: Opcode 6'b101011 stores `rt` at byte address rs + sign-extended offset. It does not write the register file. No other opcode writes data memory.
- R6: Opcode 6'b000100 compares rs and rt by subtraction. When they are equal, the next PC is PC + 4 + (sign-extended offset << 2). When they differ, the next PC is PC + 4. A branch writes nothing.
- R7: Register 0 always reads as zero. A write aimed at it shows on the write-back port but has no effect.
- R8: Any other opcode writes neither the register file nor data memory, and it advances the PC by 4.
- R9: When `prog_we` is high, `prog_data` is written at the next rising edge to word `prog_addr`. With `prog_sel`=0 it goes to the instruction store; with `prog_sel`=1 it goes to the data store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Preload write strobe |
| prog_sel | input | 1 | Preload target: 0 instruction store, 1 data store |
| prog_addr | input | MEM_AW | Preload word index |
| prog_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter (byte address) |
| rf_we_o | output | 1 | Register write enable this cycle |
| rf_waddr_o | output | 5 | Register write address (rt or rd) |
| rf_wdata_o | output | 32 | Register write data (ALU or memory) |
| dm_we_o | output | 1 | Data store write enable this cycle |
| dm_addr_o | output | 32 | Data byte address (ALU result) |
| dm_wdata_o | output | 32 | Data store write value (rt) |

## Verification
A register write-back and the operand read that depends on it meet at one clock edge. The same holds for a store and a later load of the same word. The program stores a sum and then reloads it. It then branches on equality between that reloaded register and the original sum, and the branch must be taken. A later store uses the reloaded register as its base with a negative offset. A load of that word must return the stored value. Every row of the expected-result table fixes the PC and both write ports, so a value that is stale by one cycle shows up as a wrong PC or a wrong write-back.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic              prog_sel,
  input  logic [MEM_AW-1:0] prog_addr,
  input  logic [31:0]       prog_data,
  output logic [31:0]       pc_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o,
  output logic              dm_we_o,
  output logic [31:0]       dm_addr_o,
  output logic [31:0]       dm_wdata_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [5:0] OP_REG = 6'b000000;
  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] regs [32];

  logic [31:0] pc, instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm;

  logic       reg_dst, reg_write, alu_src, mem_read, mem_write, mem_to_reg, branch;
  logic [1:0] alu_op;
  logic [2:0] alu_ctl;

  logic [31:0] rs_val, rt_val, sext, br_off, opnd_b, alu_res, rd_data, wb_data;
  logic [31:0] pc_plus4, br_tgt, pc_next;
  logic [4:0]  waddr;
  logic        zero, pc_src;

  assign instr  = imem[pc[MEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];

  always_comb begin
    reg_dst    = 1'b0;
    reg_write  = 1'b0;
    alu_src    = 1'b0;
    mem_read   = 1'b0;
    mem_write  = 1'b0;
    mem_to_reg = 1'b0;
    branch     = 1'b0;
    alu_op     = 2'b00;
    case (opcode)
      OP_REG: begin reg_dst = 1'b1; reg_write = 1'b1; alu_op = 2'b10; end
      OP_LW:  begin alu_src = 1'b1; reg_write = 1'b1; mem_read = 1'b1; mem_to_reg = 1'b1; end
      OP_SW:  begin alu_src = 1'b1; mem_write = 1'b1; end
      OP_BEQ: begin branch = 1'b1; alu_op = 2'b01; end
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b00: alu_ctl = 3'd0;
      2'b01: alu_ctl = 3'd1;
      default:
        case (funct)
          FN_ADD:  alu_ctl = 3'd0;
          FN_SUB:  alu_ctl = 3'd1;
          FN_AND:  alu_ctl = 3'd2;
          FN_OR:   alu_ctl = 3'd3;
          FN_SLT:  alu_ctl = 3'd4;
          default: alu_ctl = 3'd7;
        endcase
    endcase
  end

  assign rs_val = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign rt_val = (rt == 5'd0) ? 32'd0 : regs[rt];
  assign sext   = {{16{imm[15]}}, imm};
  assign br_off = {sext[29:0], 2'b00};
  assign opnd_b = alu_src ? sext : rt_val;

  always_comb begin
    case (alu_ctl)
      3'd0:    alu_res = rs_val + opnd_b;
      3'd1:    alu_res = rs_val - opnd_b;
      3'd2:    alu_res = rs_val & opnd_b;
      3'd3:    alu_res = rs_val | opnd_b;
      3'd4:    alu_res = {31'd0, $signed(rs_val) < $signed(opnd_b)};
      default: alu_res = 32'd0;
    endcase
  end
  assign zero = (alu_res == 32'd0);

  assign rd_data = mem_read ? dmem[alu_res[MEM_AW+1:2]] : 32'd0;
  assign wb_data = mem_to_reg ? rd_data : alu_res;
  assign waddr   = reg_dst ? rd : rt;

  assign pc_plus4 = pc + 32'd4;
  assign br_tgt   = pc_plus4 + br_off;
  assign pc_src   = branch & zero;
  assign pc_next  = pc_src ? br_tgt : pc_plus4;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pc <= 32'd0;
    else        pc <= pc_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
    end else if (reg_write && waddr != 5'd0) begin
      regs[waddr] <= wb_data;
    end

  always_ff @(posedge clk) begin
    if (prog_we && !prog_sel) imem[prog_addr] <= prog_data;
    if (prog_we && prog_sel) dmem[prog_addr] <= prog_data;
    else if (mem_write && rst_n) dmem[alu_res[MEM_AW+1:2]] <= rt_val;
  end

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc[1:0], pc[31:MEM_AW+2], alu_res[1:0], alu_res[31:MEM_AW+2], sext[31:30]};

  assign pc_o       = pc;
  assign rf_we_o    = reg_write;
  assign rf_waddr_o = waddr;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = mem_write;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = rt_val;
endmodule

module sc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [5:0]  opcode,
  input logic        branch,
  input logic        zero,
  input logic [31:0] sext,
  input logic        rf_we,
  input logic        dm_we
);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(branch && zero) |=> pc == $past(pc) + 32'd4);
  // R6
  br_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (branch && zero) |=> pc == $past(pc) + 32'd4 + {$past(sext[29:0]), 2'b00});
  // R5
  store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> opcode == 6'b101011);
  // R8
  wb_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (opcode == 6'b000000 || opcode == 6'b100011));
  // R5
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && dm_we));
  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
endmodule

bind sc_core sc_core_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .pc     (pc),
  .opcode (opcode),
  .branch (branch),
  .zero   (zero),
  .sext   (sext),
  .rf_we  (reg_write),
  .dm_we  (mem_write)
);

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
  localparam int MEM_AW = 6;
  localparam int NV = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0, prog_sel = 1'b0;
  logic [MEM_AW-1:0] prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sc_core #(.MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_sel(prog_sel),
    .prog_addr(prog_addr), .prog_data(prog_data), .pc_o(pc_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .dm_we_o(dm_we_o), .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  // {pc, rf_we, rf_waddr, rf_wdata, dm_we, dm_addr, dm_wdata}
  localparam logic [134:0] VEC [NV] = '{
    {32'd0,  1'b1, 5'd1,  32'd7,          1'b0, 32'd0,  32'd0},
    {32'd4,  1'b1, 5'd2,  32'hFFFF_FFFD,  1'b0, 32'd0,  32'd0},
    {32'd8,  1'b1, 5'd3,  32'd4,          1'b0, 32'd0,  32'd0},
    {32'd12, 1'b1, 5'd4,  32'd10,         1'b0, 32'd0,  32'd0},
    {32'd16, 1'b1, 5'd5,  32'd5,          1'b0, 32'd0,  32'd0},
    {32'd20, 1'b1, 5'd6,  32'hFFFF_FFFF,  1'b0, 32'd0,  32'd0},
    {32'd24, 1'b1, 5'd7,  32'd1,          1'b0, 32'd0,  32'd0},
    {32'd28, 1'b1, 5'd8,  32'd0,          1'b0, 32'd0,  32'd0},
    {32'd32, 1'b0, 5'd0,  32'd0,          1'b1, 32'd16, 32'd4},
    {32'd36, 1'b1, 5'd9,  32'd4,          1'b0, 32'd0,  32'd0},
    {32'd40, 1'b1, 5'd0,  32'd14,         1'b0, 32'd0,  32'd0},
    {32'd44, 1'b1, 5'd10, 32'd0,          1'b0, 32'd0,  32'd0},
    {32'd48, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0},
    {32'd52, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0},
    {32'd64, 1'b0, 5'd0,  32'd0,          1'b1, 32'd0,  32'd10},
    {32'd68, 1'b1, 5'd12, 32'd10,         1'b0, 32'd0,  32'd0},
    {32'd72, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0},
    {32'd76, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0},
    {32'd76, 1'b0, 5'd0,  32'd0,          1'b0, 32'd0,  32'd0}
  };

  function automatic string tag(int i);
    case (i)
      0, 1, 9, 15:          return "R4";
      2, 3, 4, 5, 6, 7:     return "R3";
      8, 14:                return "R5";
      10, 11:               return "R7";
      12, 13, 17:           return "R6";
      16:                   return "R8";
      default:              return "R2";
    endcase
  endfunction

  function automatic logic [31:0] rins(int s, int t, int d, logic [5:0] fn);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iins(logic [5:0] op, int s, int t, logic [15:0] im);
    return {op, 5'(s), 5'(t), im};
  endfunction

  task automatic put(input logic sel, input int a, input logic [31:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_sel = sel; prog_addr = MEM_AW'(a); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic check_row(int i);
    logic [134:0] v;
    logic ok;
    v = VEC[i];
    ok = (pc_o == v[134:103]) && (rf_we_o == v[102]) && (dm_we_o == v[64]);
    if (v[102]) ok = ok && (rf_waddr_o == v[101:97]) && (rf_wdata_o == v[96:65]);
    if (v[64])  ok = ok && (dm_addr_o == v[63:32]) && (dm_wdata_o == v[31:0]);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s row %0d: got pc=%0d we=%b wa=%0d wd=%h dwe=%b da=%h dd=%h exp pc=%0d we=%b wa=%0d wd=%h dwe=%b da=%h dd=%h",
        tag(i), i, pc_o, rf_we_o, rf_waddr_o, rf_wdata_o, dm_we_o, dm_addr_o, dm_wdata_o,
        v[134:103], v[102], v[101:97], v[96:65], v[64], v[63:32], v[31:0]);
    end
  endtask

  task automatic check1(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9 preload both stores under reset
    put(1'b1, 0, 32'd7);
    put(1'b1, 1, 32'hFFFF_FFFD);
    put(1'b0, 0,  iins(6'b100011, 0, 1, 16'd0));
    put(1'b0, 1,  iins(6'b100011, 0, 2, 16'd4));
    put(1'b0, 2,  rins(1, 2, 3, 6'h20));
    put(1'b0, 3,  rins(1, 2, 4, 6'h22));
    put(1'b0, 4,  rins(1, 2, 5, 6'h24));
    put(1'b0, 5,  rins(1, 2, 6, 6'h25));
    put(1'b0, 6,  rins(2, 1, 7, 6'h2A));
    put(1'b0, 7,  rins(1, 2, 8, 6'h2A));
    put(1'b0, 8,  iins(6'b101011, 0, 3, 16'd16));
    put(1'b0, 9,  iins(6'b100011, 0, 9, 16'd16));
    put(1'b0, 10, rins(1, 1, 0, 6'h20));
    put(1'b0, 11, rins(0, 0, 10, 6'h20));
    put(1'b0, 12, iins(6'b000100, 1, 2, 16'd5));
    put(1'b0, 13, iins(6'b000100, 3, 9, 16'd2));
    put(1'b0, 14, rins(1, 1, 11, 6'h20));
    put(1'b0, 15, rins(1, 1, 11, 6'h20));
    put(1'b0, 16, iins(6'b101011, 9, 4, 16'hFFFC));
    put(1'b0, 17, iins(6'b100011, 0, 12, 16'd0));
    put(1'b0, 18, 32'hFC00_0000);
    put(1'b0, 19, iins(6'b000100, 0, 0, 16'hFFFF));

    // R1 reset state
    #1;
    check1("R1", pc_o, 32'd0);

    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      check_row(i);
    end

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check1("R1", pc_o, 32'd0);
    @(posedge clk);
    #1;
    check1("R1", pc_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 data store kept across reset: word 0 now holds the stored 10
    check1("R9", {31'd0, rf_we_o}, 32'd1);
    check1("R9", rf_wdata_o, 32'd10);
    @(negedge clk);
    #1;
    check1("R2", pc_o, 32'd4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule